// File: doc/BRIEF.md
# Watchdog and Memory Control Register

This unit is a special-function register of a small 8-bit microcontroller. It holds one control byte that governs the watchdog timer and the path to an on-chip nonvolatile data memory, and it contains the watchdog counter that the byte controls. The CPU reaches the byte through a byte-wide SFR port: a write strobe, an address and write data, plus a read-data bus. A periodic timebase tick drives the watchdog. The nonvolatile memory supplies a busy indication and a write-attempt strobe.

The outputs are:
- a one-cycle watchdog reset request;
- the data-pointer bank select;
- the enable that steers data-pointer accesses to internal memory;
- the nonvolatile write enable;
- a pass or reject verdict for each write attempt to the nonvolatile memory.

Bit 1 does two jobs. Writing 1 to it restarts the watchdog. Reading it returns the memory ready flag.

Top module: `wdmc_ctrl`

## Requirements
- R1: After reset, a read at the register address returns 0x02 while `nv_busy` is low. The bank select, access enable, write enable and reset request are all low.
- R2: The register is decoded only at SFR address 0x96. A read at any other address returns 0x00. A write at any other address leaves the register unchanged.
- R3: The byte layout is as follows. Bits [7:5] are the prescaler. Bit 4 is the nonvolatile write enable (`nv_write_en`). Bit 3 is the internal access enable (`nv_access_en`). Bit 2 is the bank select (`dp_bank`, 0 selects bank 0 and 1 selects bank 1). Bit 0 is the watchdog enable. Each output follows its written bit from the cycle after the write.
- R4: Reading bit 1 returns the inverse of `nv_busy`: 1 when the memory is ready and 0 while it is programming.
- R5: Writing 1 to bit 1 restarts the watchdog count from zero. The written value is not stored and never appears on a read.
- R6: With the watchdog enabled and prescaler value p, `wdt_rst_req` rises in the cycle after the edge that samples tick number BASE_TICKS·2^p since the count last restarted. The timeout therefore doubles with each prescaler step.
- R7: `wdt_rst_req` lasts exactly one cycle, and the count restarts from zero, so the next request follows after another full period.
- R8: Clearing the watchdog enable, or writing a new prescaler value, clears the running count. While the watchdog is disabled, no request is ever issued.
- R9: A write attempt (`nv_wr_try`) raises `nv_wr_go` in the same cycle only when both the access enable and the write enable are 1. Otherwise it raises `nv_wr_reject` and not `nv_wr_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, valid in the same cycle |
| tick | input | 1 | Watchdog timebase tick, one cycle wide |
| nv_busy | input | 1 | Nonvolatile memory is programming |
| nv_wr_try | input | 1 | Write attempt to the nonvolatile memory |
| nv_wr_go | output | 1 | Write attempt allowed |
| nv_wr_reject | output | 1 | Write attempt refused |
| dp_bank | output | 1 | Data-pointer bank select |
| nv_access_en | output | 1 | Steer data-pointer accesses to internal memory |
| nv_write_en | output | 1 | Nonvolatile write enable |
| wdt_rst_req | output | 1 | Watchdog reset request, one cycle |

## Verification
Read data, the ready bit and the write verdict are combinational, so the bench checks them shortly after it drives the inputs, with no clock edge in between. Control outputs change at the edge that captures a write, and the bench samples them at the following falling edge. The watchdog request rises one edge after the terminal tick is sampled. The bench raises each tick for exactly one cycle and looks at the request at the falling edge right after that tick. It also counts request pulses at every falling edge, which shows that a request lasts one cycle and that none appears early or while the watchdog is disabled.

// File: rtl/wdmc_pkg.sv
package wdmc_pkg;
  localparam int PS_W = 3;
  localparam logic [7:0] SFR_ADDR_DEF = 8'h96;

  typedef struct packed {
    logic [PS_W-1:0] ps;
    logic            nv_wen;
    logic            nv_acc;
    logic            bank;
    logic            wd_en;
  } ctl_t;
endpackage

// File: rtl/wdmc_regs.sv
module wdmc_regs
  import wdmc_pkg::*;
#(
  parameter logic [7:0] SFR_ADDR = SFR_ADDR_DEF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sfr_addr,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_wdata,
  input  logic       nv_busy,
  output logic [7:0] sfr_rdata,
  output ctl_t       ctl,
  output logic       kick,
  output logic       cfg_clr
);
  logic hit, wr_hit;
  ctl_t ctl_q, ctl_d;
  logic kick_q, kick_d;

  always_comb begin
    hit     = (sfr_addr == SFR_ADDR);
    wr_hit  = hit & sfr_wr;
    ctl_d   = '{ps: sfr_wdata[7:5], nv_wen: sfr_wdata[4], nv_acc: sfr_wdata[3],
                bank: sfr_wdata[2], wd_en: sfr_wdata[0]};
    kick_d  = wr_hit & sfr_wdata[1];
    cfg_clr = wr_hit & (sfr_wdata[7:5] != ctl_q.ps);
    sfr_rdata = hit ? {ctl_q.ps, ctl_q.nv_wen, ctl_q.nv_acc, ctl_q.bank, ~nv_busy, ctl_q.wd_en}
                    : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      kick_q <= 1'b0;
    end else begin
      if (wr_hit) ctl_q <= ctl_d;
      kick_q <= kick_d;
    end
  end

  assign ctl  = ctl_q;
  assign kick = kick_q;
endmodule

// File: rtl/wdmc_wdt.sv
module wdmc_wdt
  import wdmc_pkg::*;
#(
  parameter int BASE_TICKS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            en,
  input  logic [PS_W-1:0] ps,
  input  logic            clr,
  output logic            req
);
  localparam int MAX_LIM = BASE_TICKS * (1 << ((1 << PS_W) - 1));
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             req_q, req_d;

  always_comb begin
    limit = CNT_W'(BASE_TICKS) << ps;
    cnt_d = cnt_q;
    req_d = 1'b0;
    if (!en || clr) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == limit - 1'b1) begin
        cnt_d = '0;
        req_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/wdmc_nvgate.sv
module wdmc_nvgate (
  input  logic try_wr,
  input  logic acc_en,
  input  logic wr_en,
  output logic go,
  output logic reject
);
  logic allow;
  always_comb begin
    allow  = acc_en & wr_en;
    go     = try_wr & allow;
    reject = try_wr & ~allow;
  end
endmodule

// File: rtl/wdmc_ctrl.sv
module wdmc_ctrl
  import wdmc_pkg::*;
#(
  parameter logic [7:0] SFR_ADDR   = SFR_ADDR_DEF,
  parameter int         BASE_TICKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sfr_addr,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  input  logic       tick,
  input  logic       nv_busy,
  input  logic       nv_wr_try,
  output logic       nv_wr_go,
  output logic       nv_wr_reject,
  output logic       dp_bank,
  output logic       nv_access_en,
  output logic       nv_write_en,
  output logic       wdt_rst_req
);
  logic [1:0] rsync_q;
  logic       rst_n_s;
  ctl_t       ctl;
  logic       kick, cfg_clr, wd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  wdmc_regs #(.SFR_ADDR(SFR_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .nv_busy(nv_busy), .sfr_rdata(sfr_rdata),
    .ctl(ctl), .kick(kick), .cfg_clr(cfg_clr)
  );

  wdmc_wdt #(.BASE_TICKS(BASE_TICKS)) u_wdt (
    .clk(clk), .rst_n(rst_n_s), .tick(tick), .en(ctl.wd_en), .ps(ctl.ps),
    .clr(kick | cfg_clr), .req(wdt_rst_req)
  );

  wdmc_nvgate u_gate (
    .try_wr(nv_wr_try), .acc_en(ctl.nv_acc), .wr_en(ctl.nv_wen),
    .go(nv_wr_go), .reject(nv_wr_reject)
  );

  assign wd_en        = ctl.wd_en;
  assign dp_bank      = ctl.bank;
  assign nv_access_en = ctl.nv_acc;
  assign nv_write_en  = ctl.nv_wen;
endmodule

// File: rtl/wdmc_chk.sv
module wdmc_chk #(
  parameter logic [7:0] SFR_ADDR = 8'h96
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] sfr_addr,
  input logic       sfr_wr,
  input logic [7:0] sfr_wdata,
  input logic [7:0] sfr_rdata,
  input logic       nv_busy,
  input logic       nv_wr_try,
  input logic       nv_wr_go,
  input logic       nv_wr_reject,
  input logic       wdt_rst_req,
  input logic       wd_en
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> !wdt_rst_req); // R7
  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |=> !wdt_rst_req); // R8
  AST_KICK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == SFR_ADDR && sfr_wdata[1]) |-> ##2 !wdt_rst_req); // R5
  AST_GO_REJ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nv_wr_go && nv_wr_reject)); // R9
  AST_TRY_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr_try |-> $countones({nv_wr_go, nv_wr_reject}) == 1); // R9
  AST_READY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == SFR_ADDR) |-> (sfr_rdata[1] == !nv_busy)); // R4
  AST_OFF_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr != SFR_ADDR) |-> (sfr_rdata == 8'h00)); // R2
endmodule

bind wdmc_ctrl wdmc_chk #(.SFR_ADDR(SFR_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
  .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .nv_busy(nv_busy),
  .nv_wr_try(nv_wr_try), .nv_wr_go(nv_wr_go), .nv_wr_reject(nv_wr_reject),
  .wdt_rst_req(wdt_rst_req), .wd_en(wd_en)
);

// File: tb/tb_wdmc_ctrl.sv
module tb_wdmc_ctrl;
  localparam int         BASE = 4;
  localparam logic [7:0] ADR  = 8'h96;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] sfr_addr = ADR, sfr_wdata = 8'h00, sfr_rdata;
  logic sfr_wr = 1'b0, tick = 1'b0, nv_busy = 1'b0, nv_wr_try = 1'b0;
  logic nv_wr_go, nv_wr_reject, dp_bank, nv_access_en, nv_write_en, wdt_rst_req;

  int n_chk = 0, n_fail = 0, req_cnt = 0;

  always #5 clk = ~clk;

  wdmc_ctrl #(.SFR_ADDR(ADR), .BASE_TICKS(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .tick(tick), .nv_busy(nv_busy),
    .nv_wr_try(nv_wr_try), .nv_wr_go(nv_wr_go), .nv_wr_reject(nv_wr_reject),
    .dp_bank(dp_bank), .nv_access_en(nv_access_en), .nv_write_en(nv_write_en),
    .wdt_rst_req(wdt_rst_req)
  );

  always @(negedge clk) if (wdt_rst_req) req_cnt++;

  // {wdata, busy, try, exp_rdata, exp bank/acc/wen/go/rej}
  localparam logic [22:0] VEC [8] = '{
    {8'h00, 1'b0, 1'b1, 8'h02, 5'b00001},
    {8'h18, 1'b0, 1'b1, 8'h1A, 5'b01110},
    {8'h1C, 1'b1, 1'b0, 8'h1C, 5'b11100},
    {8'h08, 1'b1, 1'b1, 8'h08, 5'b01001},
    {8'h10, 1'b0, 1'b1, 8'h12, 5'b00101},
    {8'hE4, 1'b0, 1'b0, 8'hE6, 5'b10000},
    {8'hA6, 1'b0, 1'b0, 8'hA6, 5'b10000},
    {8'hA6, 1'b1, 1'b0, 8'hA4, 5'b10000}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0; sfr_addr = ADR;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  // n ticks: no request before the last, a request right after the last
  task automatic period(input int n, input string req);
    int c0;
    c0 = req_cnt;
    for (int i = 0; i < n - 1; i++) do_tick();
    chk(req_cnt == c0, req, req_cnt - c0, 0);
    do_tick();
    chk(wdt_rst_req === 1'b1, req, wdt_rst_req, 1);
    @(negedge clk);
    chk(wdt_rst_req === 1'b0 && req_cnt == c0 + 1, "R7", req_cnt - c0, 1);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(sfr_rdata === 8'h02, "R1", sfr_rdata, 8'h02);
    chk({dp_bank, nv_access_en, nv_write_en, wdt_rst_req} === 4'b0, "R1",
        {dp_bank, nv_access_en, nv_write_en, wdt_rst_req}, 0);

    // R3/R4/R9 vector table
    foreach (VEC[i]) begin
      wr(ADR, VEC[i][22:15]);
      nv_busy = VEC[i][14]; nv_wr_try = VEC[i][13];
      #1;
      chk(sfr_rdata === VEC[i][12:5], "R3/R4", sfr_rdata, VEC[i][12:5]);
      chk({dp_bank, nv_access_en, nv_write_en} === VEC[i][4:2], "R3",
          {dp_bank, nv_access_en, nv_write_en}, VEC[i][4:2]);
      chk({nv_wr_go, nv_wr_reject} === VEC[i][1:0], "R9",
          {nv_wr_go, nv_wr_reject}, VEC[i][1:0]);
      nv_busy = 1'b0; nv_wr_try = 1'b0;
    end

    // R2 decode
    wr(ADR, 8'h1C);
    wr(8'h95, 8'hE3);
    #1;
    chk(sfr_rdata === 8'h1E, "R2", sfr_rdata, 8'h1E);
    sfr_addr = 8'h95; #1;
    chk(sfr_rdata === 8'h00, "R2", sfr_rdata, 8'h00);
    sfr_addr = ADR;

    // R8 disabled: no requests
    wr(ADR, 8'h00);
    begin
      int c0;
      c0 = req_cnt;
      for (int i = 0; i < 3 * BASE; i++) do_tick();
      chk(req_cnt == c0, "R8", req_cnt - c0, 0);
    end

    // R6 base period, R7 repeat
    wr(ADR, 8'h01);
    period(BASE, "R6");
    period(BASE, "R7");

    // R5 restart pulse
    for (int i = 0; i < BASE - 1; i++) do_tick();
    wr(ADR, 8'h03);
    #1;
    chk(sfr_rdata === 8'h03, "R5", sfr_rdata, 8'h03);
    period(BASE, "R5");

    // R8 prescaler change clears count; R6 doubled period
    for (int i = 0; i < BASE - 1; i++) do_tick();
    wr(ADR, 8'h21);
    period(2 * BASE, "R8");

    // R8 disable then enable clears count
    for (int i = 0; i < 2 * BASE - 1; i++) do_tick();
    wr(ADR, 8'h20);
    wr(ADR, 8'h21);
    period(2 * BASE, "R8");

    // R6 largest prescaler
    wr(ADR, 8'hE1);
    period(BASE * 128, "R6");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule